// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block runs single conversions on an eight-channel, 10-bit serial converter whose successive-approximation steps are driven by the host's serial clock. A one-cycle start request latches a channel number and two mode flags: bipolar coding and differential input. The sequencer then lowers chip select and shifts out a command byte. It follows this with sixteen zero bits while it captures the converter's reply, and after the last bit it raises chip select again. The block then presents the 10-bit result, the two sub-LSB bits and a flag that tells whether the result is two's complement (bipolar) or straight binary (unipolar). All three outputs change in the same cycle as a one-cycle done strobe.

The serial clock is derived from the system clock by a runtime divider. Each SCLK half period lasts `div_i` system cycles, so a system clock of 100 MHz covers the 100 kHz to 2 MHz range with divider values of 500 down to 25. The held sample droops if the frame runs too long, so the sequencer counts system cycles from the moment it accepts a start. When the frame would overrun the limit `TIMEOUT_CYC`, the sequencer abandons it at the limit and reports a timeout.

Top module: `adc_conv_seq`

## Requirements
- R1: The command byte goes out on DIN MSB first. From bit 7 down it holds: 1, then the channel number as 3 bits MSB first, then the inverse of `bipolar_i` (1 = unipolar), then the inverse of `diff_i` (1 = single-ended), then 1, 1 (external-clock mode).
- R2: One conversion is one frame of exactly 24 rising SCLK edges with `cs_n_o` held low throughout. DIN carries zero for rising edges 9 to 24, and `cs_n_o` returns high after the 24th edge.
- R3: SCLK is low whenever `cs_n_o` is high. Each SCLK half period lasts `div_i` system cycles, and a `div_i` of 0 acts as 1. DIN changes only while SCLK is low. DOUT is captured at each rising SCLK edge.
- R4: The eight bits received during the command byte (rising edges 1 to 8) have no effect on any output.
- R5: The reply bit at rising edge 9 is skipped. The bits at edges 10 to 19 form `result_o`, MSB first. The bits at edges 20 and 21 form `sub_lsb_o`, MSB first. The bits at edges 22 to 24 are ignored.
- R6: `result_signed_o` equals the `bipolar_i` value latched at the accepted start.
- R7: `done_o` is high for exactly one cycle. With the start accepted at clock edge 0, it rises after edge 48·max(div_i,1). `result_o`, `sub_lsb_o`, `result_signed_o` and `timeout_o` change only together with `done_o`.
- R8: While `busy_o` is high, `start_i` has no effect on the frame in progress, its command byte or its completion time.
- R9: If 48·max(div_i,1) exceeds `TIMEOUT_CYC`, the frame is abandoned at edge `TIMEOUT_CYC`. At that point `cs_n_o` goes high, SCLK goes low, `done_o` pulses with `timeout_o`=1, and `result_o` and `sub_lsb_o` are 0. A frame that completes at exactly `TIMEOUT_CYC` succeeds with `timeout_o`=0.
- R10: After reset, `cs_n_o`=1, `sclk_o`=0, `busy_o`=0, `done_o`=0, `timeout_o`=0, and `result_o` and `sub_lsb_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Conversion request, honoured only when idle |
| chan_i | input | 3 | Channel number |
| bipolar_i | input | 1 | 1 = bipolar (two's complement) coding |
| diff_i | input | 1 | 1 = differential input pair |
| div_i | input | DIV_W | SCLK half period in system cycles, held stable while busy |
| sclk_o | output | 1 | Serial clock to the converter |
| cs_n_o | output | 1 | Active-low chip select |
| din_o | output | 1 | Serial data to the converter |
| dout_i | input | 1 | Serial data from the converter |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 10 | Conversion result |
| sub_lsb_o | output | 2 | Sub-LSB bits |
| result_signed_o | output | 1 | 1 = result is two's complement |
| timeout_o | output | 1 | Last frame was abandoned on the time limit |

## Verification
Normal completion of a frame and expiry of the time limit can fall on the same system clock edge. The bench sets the limit to 192 cycles and runs with a divider of 4, so the last SCLK half period ends exactly on edge 192. That frame must complete normally, with its data intact and no timeout. A divider of 5 is then used, and the frame must be cut off at edge 192 with a zero result and the timeout flag set. A start request injected in the middle of a frame is also checked, both against the frame's timing and against its command byte.

// File: rtl/adc_seq_pkg.sv
// Package adc_seq_pkg: frame geometry and command-byte encoding shared by the
// sequencer blocks. Assumes a 24-bit frame made of a command byte and two zero bytes.
package adc_seq_pkg;
    localparam int CH_W        = 3;
    localparam int RES_W       = 10;
    localparam int SUB_W       = 2;
    localparam int CMD_BITS    = 8;
    localparam int FRAME_BITS  = 3 * CMD_BITS;
    localparam int BIT_CNT_W   = $clog2(FRAME_BITS + 1);
    // Reply layout: one leading zero after the command byte, then the data.
    localparam int CAP_FIRST   = CMD_BITS + 1;
    localparam int CAP_W       = RES_W + SUB_W;
    localparam int CAP_LAST    = CAP_FIRST + CAP_W - 1;

    typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

    // Assemble the command byte: start, channel, coding, input type, clock mode.
    function automatic logic [CMD_BITS-1:0] make_cmd(
        input logic [CH_W-1:0] ch,
        input logic            bip,
        input logic            dif
    );
        return {1'b1, ch, ~bip, ~dif, 2'b11};
    endfunction
endpackage

// File: rtl/adc_sclk_gen.sv
// Module adc_sclk_gen: emits a one-cycle tick every max(div_i,1) system cycles
// while run_i is high. Each tick marks one SCLK half-period boundary.
// Assumes div_i stays stable while run_i is high.
module adc_sclk_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] wrap_at;

    // Treat a zero divider as one.
    always_comb begin
        div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
        wrap_at = div_eff - DIV_W'(1);
        tick_o  = run_i && (cnt_q >= wrap_at);
    end

    // Half-period counter, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)
            cnt_q <= '0;
        else if (cnt_q >= wrap_at)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DIV_W'(1);
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> cnt_q < div_eff);
endmodule

// File: rtl/adc_conv_timer.sv
// Module adc_conv_timer: counts system cycles while a frame runs. It raises
// expire_o at the LIMIT-th edge unless the frame finishes on that same edge.
module adc_conv_timer #(
    parameter int LIMIT = 12000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic finish_i,
    output logic expire_o
);
    localparam int EL_W = $clog2(LIMIT + 1);
    localparam logic [EL_W-1:0] LAST_EL = EL_W'(LIMIT - 1);

    logic [EL_W-1:0] el_q;

    // Expiry is suppressed when completion falls on the same edge.
    always_comb expire_o = run_i && (el_q == LAST_EL) && !finish_i;

    // Elapsed-cycle counter, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)
            el_q <= '0;
        else
            el_q <= el_q + EL_W'(1);
    end

    assert_elapsed_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> el_q < EL_W'(LIMIT));
endmodule

// File: rtl/adc_frame_shifter.sv
// Module adc_frame_shifter: holds the outgoing command byte and counts rising
// SCLK edges. It captures only the reply bits that carry result and sub-LSB
// data; the command-byte reply, the leading zero and the trailing zeros are
// never stored.
module adc_frame_shifter
    import adc_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [CMD_BITS-1:0]  cmd_i,
    input  logic                 rise_i,
    input  logic                 fall_i,
    input  logic                 dout_i,
    output logic                 din_o,
    output logic                 last_o,
    output logic [CAP_W-1:0]     cap_o
);
    localparam logic [BIT_CNT_W-1:0] FIRST_IDX = BIT_CNT_W'(CAP_FIRST);
    localparam logic [BIT_CNT_W-1:0] LAST_IDX  = BIT_CNT_W'(CAP_LAST);
    localparam logic [BIT_CNT_W-1:0] END_CNT   = BIT_CNT_W'(FRAME_BITS);

    logic [CMD_BITS-1:0]  tx_q;
    logic [BIT_CNT_W-1:0] bits_q;
    logic [CAP_W-1:0]     cap_q;
    logic                 in_window;

    // Decode which rising edges belong to the data field.
    always_comb begin
        in_window = (bits_q >= FIRST_IDX) && (bits_q <= LAST_IDX);
        din_o     = tx_q[CMD_BITS-1];
        last_o    = (bits_q == END_CNT);
        cap_o     = cap_q;
    end

    // Outgoing shift: load the command, then shift in zeros on falling SCLK.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_q <= '0;
        else if (load_i)
            tx_q <= cmd_i;
        else if (fall_i)
            tx_q <= {tx_q[CMD_BITS-2:0], 1'b0};
    end

    // Rising-edge counter for the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i)
            bits_q <= '0;
        else if (rise_i)
            bits_q <= bits_q + BIT_CNT_W'(1);
    end

    // Capture the data window of the reply at rising SCLK.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i)
            cap_q <= '0;
        else if (rise_i && in_window)
            cap_q <= {cap_q[CAP_W-2:0], dout_i};
    end

    assert_edge_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bits_q <= END_CNT);
    assert_no_extra_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> !rise_i);
endmodule

// File: rtl/adc_conv_seq.sv
// Module adc_conv_seq: top of the conversion sequencer. It accepts a start
// when idle, runs one 24-edge frame with chip select low, and returns the
// result with a one-cycle done strobe, or abandons the frame on the time limit.
// Assumes div_i is held stable while busy_o is high.
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int TIMEOUT_CYC = 12000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       chan_i,
    input  logic             bipolar_i,
    input  logic             diff_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sclk_o,
    output logic             cs_n_o,
    output logic             din_o,
    input  logic             dout_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [9:0]       result_o,
    output logic [1:0]       sub_lsb_o,
    output logic             result_signed_o,
    output logic             timeout_o
);
    seq_state_t           state_q;
    logic                 sclk_q, cs_n_q, done_q, tmo_q, sgn_q, bip_q;
    logic [RES_W-1:0]     res_q;
    logic [SUB_W-1:0]     sub_q;
    logic                 running, tick, expire, last_bit;
    logic                 load, rise, fall, finish;
    logic [CAP_W-1:0]     cap;
    logic [CMD_BITS-1:0]  cmd;

    // Strobes that steer the shifter and the timer.
    always_comb begin
        running = (state_q == ST_RUN);
        load    = !running && start_i;
        cmd     = make_cmd(chan_i, bipolar_i, diff_i);
        finish  = running && tick && sclk_q && last_bit;
        rise    = running && tick && !sclk_q && !expire;
        fall    = running && tick && sclk_q && !last_bit && !expire;
    end

    adc_sclk_gen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run_i(running), .div_i(div_i), .tick_o(tick)
    );

    adc_conv_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run_i(running), .finish_i(finish),
        .expire_o(expire)
    );

    adc_frame_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .load_i(load), .cmd_i(cmd), .rise_i(rise),
        .fall_i(fall), .dout_i(dout_i), .din_o(din_o), .last_o(last_bit),
        .cap_o(cap)
    );

    // Frame control: chip select, SCLK level, and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cs_n_q  <= 1'b1;
            sclk_q  <= 1'b0;
            done_q  <= 1'b0;
            tmo_q   <= 1'b0;
            sgn_q   <= 1'b0;
            bip_q   <= 1'b0;
            res_q   <= '0;
            sub_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!running) begin
                if (start_i) begin
                    state_q <= ST_RUN;
                    cs_n_q  <= 1'b0;
                    sclk_q  <= 1'b0;
                    bip_q   <= bipolar_i;
                end
            end else if (expire) begin
                state_q <= ST_IDLE;
                cs_n_q  <= 1'b1;
                sclk_q  <= 1'b0;
                done_q  <= 1'b1;
                tmo_q   <= 1'b1;
                sgn_q   <= bip_q;
                res_q   <= '0;
                sub_q   <= '0;
            end else if (tick) begin
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                end else if (last_bit) begin
                    state_q <= ST_IDLE;
                    cs_n_q  <= 1'b1;
                    sclk_q  <= 1'b0;
                    done_q  <= 1'b1;
                    tmo_q   <= 1'b0;
                    sgn_q   <= bip_q;
                    res_q   <= cap[CAP_W-1:SUB_W];
                    sub_q   <= cap[SUB_W-1:0];
                end else begin
                    sclk_q <= 1'b0;
                end
            end
        end
    end

    // Drive the ports from the registers.
    always_comb begin
        sclk_o          = sclk_q;
        cs_n_o          = cs_n_q;
        busy_o          = running;
        done_o          = done_q;
        result_o        = res_q;
        sub_lsb_o       = sub_q;
        result_signed_o = sgn_q;
        timeout_o       = tmo_q;
    end

    assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);
    assert_din_stable_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(din_o));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(sub_lsb_o) && $stable(timeout_o)));
    assert_start_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> ($past(start_i) && !$past(busy_o)));
    assert_timeout_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> (done_o && result_o == '0));
endmodule

// File: tb/tb_adc_conv_seq.sv
module tb_adc_conv_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 192;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] chan = '0;
    logic       bip = 1'b0, dif = 1'b0;
    logic [7:0] div = 8'd1;
    logic       sclk, cs_n, din, busy, done, sgn, tmo;
    logic       dout = 1'b0;
    logic [9:0] res;
    logic [1:0] sub;

    int total = 0;
    int bad   = 0;

    // Converter model state
    logic [23:0] resp = '0;
    logic [23:0] cap  = '0;
    int          rises = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_conv_seq #(.DIV_W(8), .TIMEOUT_CYC(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .chan_i(chan),
        .bipolar_i(bip), .diff_i(dif), .div_i(div), .sclk_o(sclk),
        .cs_n_o(cs_n), .din_o(din), .dout_i(dout), .busy_o(busy),
        .done_o(done), .result_o(res), .sub_lsb_o(sub),
        .result_signed_o(sgn), .timeout_o(tmo)
    );

    // Converter model: first reply bit on select, later bits after falling SCLK.
    always @(negedge cs_n) begin
        rises = 0;
        dout  = resp[23];
    end
    always @(posedge sclk) begin
        if (!cs_n) begin
            cap   = {cap[22:0], din};
            rises = rises + 1;
        end
    end
    always @(negedge sclk) begin
        if (!cs_n) dout = (rises < 24) ? resp[23 - rises] : 1'b0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_conv(input int ch, input int b, input int d, input int dv,
                            input int val, input int sb, input bit poke);
        int n;
        int deff;
        bit to;
        int expn;
        logic [7:0] cmd_exp;
        logic [9:0] res_seen;
        deff    = (dv == 0) ? 1 : dv;
        to      = (48 * deff) > LIMIT;
        expn    = to ? LIMIT + 1 : 48 * deff + 1;
        cmd_exp = {1'b1, ch[2:0], ~b[0], ~d[0], 2'b11};
        // First byte is junk that R4 requires to be discarded.
        resp = {8'hA5 ^ 8'(ch * 37 + val), 1'b1, val[9:0], sb[1:0], 3'b111};
        resp[15] = 1'b0;
        resp[2:0] = 3'b000;
        cap  = '0;
        @(negedge clk);
        div = 8'(dv); chan = ch[2:0]; bip = b[0]; dif = d[0]; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 20000) begin
            if (poke && n == 20) begin
                start = 1'b1; chan = ~ch[2:0]; bip = ~b[0]; dif = ~d[0];
            end
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
        end
        chk(n == expn, to ? "R9 abort cycle" : (poke ? "R8 timing with start while busy" : "R7 done cycle"), n, expn);
        chk(tmo == to, "R9 timeout flag", int'(tmo), int'(to));
        chk(cs_n == 1'b1 && sclk == 1'b0, "R3 idle after frame", int'(sclk), 0);
        chk(sgn == b[0], "R6 coding flag", int'(sgn), b);
        if (!to) begin
            chk(cap[23:16] == cmd_exp, poke ? "R8 command byte kept" : "R1 command byte",
                int'(cap[23:16]), int'(cmd_exp));
            chk(cap[15:0] == 16'h0, "R2 zero bytes on DIN", int'(cap[15:0]), 0);
            chk(rises == 24, "R2 edge count", rises, 24);
            chk(res == val[9:0], "R5 result (R4 junk first byte)", int'(res), val);
            chk(sub == sb[1:0], "R5 sub-LSB", int'(sub), sb);
        end else begin
            chk(res == 10'd0 && sub == 2'd0, "R9 zero result", int'(res), 0);
        end
        res_seen = res;
        @(negedge clk);
        chk(done == 1'b0, "R7 single-cycle done", int'(done), 0);
        chk(res == res_seen, "R7 result held", int'(res), int'(res_seen));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(cs_n == 1'b1, "R10 cs_n", int'(cs_n), 1);
        chk(sclk == 1'b0, "R10 sclk", int'(sclk), 0);
        chk(busy == 1'b0 && done == 1'b0, "R10 busy/done", int'(busy), 0);
        chk(tmo == 1'b0 && res == 10'd0 && sub == 2'd0, "R10 results", int'(res), 0);

        // Full sweep of channel and mode flags at the fastest rate.
        for (int c = 0; c < 8; c++)
            for (int b = 0; b < 2; b++)
                for (int d = 0; d < 2; d++)
                    run_conv(c, b, d, 1, (c * 97 + b * 300 + d * 511 + 5) % 1024,
                             (c + b + d) % 4, 1'b0);

        // Divider variants and extreme codes; div 0 behaves as 1 (R3).
        run_conv(3, 0, 0, 0, 1023, 3, 1'b0);
        run_conv(5, 1, 0, 2, 0, 0, 1'b0);
        run_conv(6, 0, 1, 3, 512, 2, 1'b0);
        run_conv(1, 1, 1, 3, 341, 1, 1'b0);
        // Completion and limit on the same edge (48*4 == LIMIT): R9 completes.
        run_conv(7, 1, 0, 4, 682, 1, 1'b0);
        // Start pulse mid-frame must be ignored (R8).
        run_conv(2, 0, 1, 2, 777, 2, 1'b1);
        // Frame longer than the limit: abandoned (R9).
        run_conv(4, 1, 1, 5, 600, 3, 1'b0);
        // Normal frame still works after an abort.
        run_conv(0, 0, 0, 1, 123, 1, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule